// File: doc/BRIEF.md
# Triplet Coincidence Matcher

This block searches for three-plane track candidates. Two outer detector planes each supply a hit pattern as a bit array, one bit per bin. Hits on the centre plane arrive one at a time over a valid/ready stream. For each centre hit at bin `p`, the block lines the two outer patterns up around `p`. A straight track through the centre bin reaches the first outer plane at `p + d` and the second at `p - d`. The block then ANDs the aligned pairs over a window of `WIN` offsets.

Every set bit in that AND is a candidate triplet. Candidates are sent downstream one per transfer on a second valid/ready stream, in ascending offset order. Each carries the centre bin, the window offset and both outer bins. No candidate is filtered or merged here; fake combinations are passed on for later cut stages. A halt input freezes the loop when the downstream stage cannot take more.

Top module: `tcm_matcher`

## Requirements
- R1: Once reset is released, `cand_valid` is 0 and, with `halt` low, `ctr_ready` is 1.
- R2: For a centre hit at bin `p`, window slot `j` (0 ≤ j < WIN, HALF = WIN/2) matches exactly when bit `p+j-HALF` of `arr_a` and bit `p-j+HALF` of `arr_c` are both 1. Bit `i` of each array is bin `i` (bit 0 is bin 0). The arrays are sampled in the cycle the centre hit is accepted, and later changes have no effect on that hit.
- R3: A slot whose first-plane bin or second-plane bin lies outside 0..NBINS-1 never matches.
- R4: Every matching slot is delivered exactly once, one per `cand_valid && cand_ready` transfer. No other candidate is produced for that hit.
- R5: The candidates of one hit come out in strictly ascending `cand_off` order.
- R6: While `cand_valid` is high and `cand_ready` is low, `cand_off`, `cand_ctr`, `cand_abin` and `cand_cbin` hold their values into the next cycle.
- R7: `ctr_ready` stays low while any candidate of the current hit is still unaccepted. It returns high in the cycle after the last candidate is accepted.
- R8: A centre hit with no matching slot takes one cycle. No candidate appears, and `ctr_ready` is high again in the next cycle.
- R9: While `halt` is high, `cand_valid` and `ctr_ready` are both low and no pending candidate is lost. Delivery resumes with the same candidate once `halt` falls.
- R10: For a candidate at slot `j` of centre bin `p`: `cand_ctr` = p, `cand_off` = j (binary), `cand_abin` = p+j-HALF and `cand_cbin` = p-j+HALF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 1 | Stalls the matching loop and candidate output |
| arr_a | input | NBINS | First outer plane hit pattern, bit i = bin i |
| arr_c | input | NBINS | Second outer plane hit pattern, bit i = bin i |
| ctr_valid | input | 1 | Centre hit available |
| ctr_ready | output | 1 | Centre hit is popped this cycle when valid |
| ctr_bin | input | log2(NBINS) | Centre hit bin |
| cand_valid | output | 1 | Candidate triplet available |
| cand_ready | input | 1 | Downstream accepts the candidate |
| cand_ctr | output | log2(NBINS) | Centre bin of the candidate |
| cand_off | output | log2(WIN) | Window slot of the candidate |
| cand_abin | output | log2(NBINS) | First outer plane bin of the candidate |
| cand_cbin | output | log2(NBINS) | Second outer plane bin of the candidate |

## Verification
The hardest case is a hit whose AND holds many set bits while the downstream side stalls and `halt` pulses in the middle of the drain. Only that case shows that the clear-one-bit serializer neither skips nor repeats a candidate, and that the centre stream stays blocked throughout. The stimulus sweeps every centre bin against several fixed outer patterns: all-ones to fill the window, edge-only and irregular words, and one pattern that matches nothing. It holds `cand_ready` low for a number of cycles derived from the bin and slot, and raises `halt` both mid-drain and while a hit is waiting. After each pop the outer arrays are inverted, so a late sample of the arrays shows up as wrong candidates.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  // Default geometry of the matcher
  localparam int TCM_NBINS = 32;
  localparam int TCM_WIN   = 8;
endpackage

// File: rtl/tcm_window.sv
// Aligns both outer patterns on the centre bin and ANDs them per window slot.
module tcm_window #(
  parameter int NBINS = 32,
  parameter int WIN   = 8,
  parameter int BW    = 5
) (
  input  logic [NBINS-1:0] arr_a,
  input  logic [NBINS-1:0] arr_c,
  input  logic [BW-1:0]    ctr_bin,
  output logic [WIN-1:0]   match
);
  localparam int HALF = WIN / 2;

  // Bin of the first outer plane for slot j
  function automatic int bin_a(input int p, input int j);
    return p + j - HALF;
  endfunction

  // Bin of the second outer plane for slot j (mirror of bin_a)
  function automatic int bin_c(input int p, input int j);
    return p - j + HALF;
  endfunction

  // Bit of a pattern at a signed bin; bins off the plane read as empty
  function automatic logic pick(input logic [NBINS-1:0] v, input int idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NBINS; k++)
      if (k == idx) r = v[k];
    return r;
  endfunction

  for (genvar j = 0; j < WIN; j++) begin : g_slot
    assign match[j] = pick(arr_a, bin_a(int'(ctr_bin), j))
                    & pick(arr_c, bin_c(int'(ctr_bin), j));
  end
endmodule

// File: rtl/tcm_serializer.sv
// Holds the AND result of one centre hit and hands out its set bits lowest first.
module tcm_serializer #(
  parameter int WIN = 8,
  parameter int OW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WIN-1:0] load_mask,
  input  logic           take,
  output logic           busy,
  output logic [OW-1:0]  lo_off
);
  logic [WIN-1:0] pend_q;

  function automatic logic [OW-1:0] lowest(input logic [WIN-1:0] m);
    logic [OW-1:0] r;
    r = '0;
    for (int i = WIN - 1; i >= 0; i--)
      if (m[i]) r = OW'(i);
    return r;
  endfunction

  function automatic logic [WIN-1:0] onehot(input logic [OW-1:0] off);
    logic [WIN-1:0] r;
    r = '0;
    for (int i = 0; i < WIN; i++)
      if (OW'(i) == off) r[i] = 1'b1;
    return r;
  endfunction

  assign busy   = |pend_q;
  assign lo_off = lowest(pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= '0;
    else if (load)  pend_q <= load_mask;
    else if (take)  pend_q <= pend_q & ~onehot(lo_off);
  end

  // A new mask is only loaded once the previous one is drained
  assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  // Each transfer removes exactly one pending match
  assert_drain_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
  // Successive matches of one hit rise in offset
  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ($countones(pend_q) > 1)) |=> (lo_off > $past(lo_off)));
endmodule

// File: rtl/tcm_matcher.sv
// Centre-hit loop: pop a hit, capture its window AND, drain matches one by one.
module tcm_matcher
  import tcm_pkg::*;
#(
  parameter int NBINS = TCM_NBINS,
  parameter int WIN   = TCM_WIN,
  localparam int BW   = $clog2(NBINS),
  localparam int OW   = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [NBINS-1:0] arr_a,
  input  logic [NBINS-1:0] arr_c,
  input  logic             ctr_valid,
  output logic             ctr_ready,
  input  logic [BW-1:0]    ctr_bin,
  output logic             cand_valid,
  input  logic             cand_ready,
  output logic [BW-1:0]    cand_ctr,
  output logic [OW-1:0]    cand_off,
  output logic [BW-1:0]    cand_abin,
  output logic [BW-1:0]    cand_cbin
);
  localparam int HALF = WIN / 2;

  // Named internal events used by the assertions
  logic           hit_pop;
  logic           cand_take;
  logic           busy;
  logic [WIN-1:0] win_mask;
  logic [BW-1:0]  ctr_q;
  logic [OW-1:0]  lo_off;

  tcm_window #(.NBINS(NBINS), .WIN(WIN), .BW(BW)) u_window (
    .arr_a   (arr_a),
    .arr_c   (arr_c),
    .ctr_bin (ctr_bin),
    .match   (win_mask)
  );

  assign ctr_ready  = !halt && !busy;
  assign hit_pop    = ctr_valid && ctr_ready;
  assign cand_valid = busy && !halt;
  assign cand_take  = cand_valid && cand_ready;

  tcm_serializer #(.WIN(WIN), .OW(OW)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hit_pop),
    .load_mask (win_mask),
    .take      (cand_take),
    .busy      (busy),
    .lo_off    (lo_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctr_q <= '0;
    else if (hit_pop) ctr_q <= ctr_bin;
  end

  // Modular arithmetic is exact for every slot that can match
  assign cand_ctr  = ctr_q;
  assign cand_off  = lo_off;
  assign cand_abin = ctr_q + BW'(lo_off) - BW'(HALF);
  assign cand_cbin = ctr_q - BW'(lo_off) + BW'(HALF);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!cand_valid && !ctr_ready));
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !ctr_ready);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_ready) |=> ($stable(cand_off) && $stable(cand_ctr)));
  assert_empty_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pop && (win_mask == '0)) |=> (!cand_valid && !halt) || halt);
  assert_empty_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pop && (win_mask == '0)) |=> !busy);
endmodule

// File: tb/tcm_matcher_tb.sv
`timescale 1ns/1ps
module tcm_matcher_tb;
  localparam int NB   = 32;
  localparam int WN   = 8;
  localparam int BW   = 5;
  localparam int OW   = 3;
  localparam int HALF = WN / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          halt = 1'b0;
  logic [NB-1:0] arr_a = '0;
  logic [NB-1:0] arr_c = '0;
  logic          ctr_valid = 1'b0;
  logic          ctr_ready;
  logic [BW-1:0] ctr_bin = '0;
  logic          cand_valid;
  logic          cand_ready = 1'b0;
  logic [BW-1:0] cand_ctr;
  logic [OW-1:0] cand_off;
  logic [BW-1:0] cand_abin;
  logic [BW-1:0] cand_cbin;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tcm_matcher #(.NBINS(NB), .WIN(WN)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .arr_a(arr_a), .arr_c(arr_c),
    .ctr_valid(ctr_valid), .ctr_ready(ctr_ready), .ctr_bin(ctr_bin),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_ctr(cand_ctr),
    .cand_off(cand_off), .cand_abin(cand_abin), .cand_cbin(cand_cbin)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected matches, found by walking the first plane's hits
  function automatic logic [WN-1:0] model(input logic [NB-1:0] a,
                                          input logic [NB-1:0] c, input int p);
    logic [WN-1:0] m;
    m = '0;
    for (int ab = 0; ab < NB; ab++) begin
      int cb, slot;
      cb   = 2 * p - ab;
      slot = ab - p + HALF;
      if (a[ab] && slot >= 0 && slot < WN && cb >= 0 && cb < NB && c[cb])
        m[slot] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [NB-1:0] pat_a(input int k);
    case (k)
      0: return '1;
      1: return '1;
      2: return 32'h9E37_79B9;
      3: return 32'h0F0F_33CC;
      default: return 32'h8000_0001;
    endcase
  endfunction

  function automatic logic [NB-1:0] pat_c(input int k);
    case (k)
      0: return '1;
      1: return '0;
      2: return 32'h7F4A_7C15;
      3: return 32'hF0E1_5A69;
      default: return 32'h8000_0001;
    endcase
  endfunction

  task automatic check_cand(input int p, input int j, input string tag);
    chk(cand_valid == 1'b1, "R4", {tag, " cand_valid"}, int'(cand_valid), 1);
    chk(int'(cand_off) == j, "R5", {tag, " cand_off"}, int'(cand_off), j);
    chk(int'(cand_ctr) == p, "R10", {tag, " cand_ctr"}, int'(cand_ctr), p);
    chk(int'(cand_abin) == p + j - HALF, "R10", {tag, " cand_abin"},
        int'(cand_abin), p + j - HALF);
    chk(int'(cand_cbin) == p - j + HALF, "R10", {tag, " cand_cbin"},
        int'(cand_cbin), p - j + HALF);
    chk(ctr_ready == 1'b0, "R7", {tag, " ctr_ready while pending"},
        int'(ctr_ready), 0);
  endtask

  task automatic run_hit(input int k, input int p, input bit halt_idle,
                         input bit halt_mid);
    logic [NB-1:0] a, c;
    logic [WN-1:0] m;
    bit first;
    a = pat_a(k);
    c = pat_c(k);
    m = model(a, c, p);
    @(negedge clk);
    arr_a = a; arr_c = c; ctr_bin = BW'(p); ctr_valid = 1'b1;
    if (halt_idle) begin
      halt = 1'b1;
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        chk(ctr_ready == 1'b0, "R9", "ctr_ready under halt", int'(ctr_ready), 0);
        chk(cand_valid == 1'b0, "R9", "cand_valid under halt", int'(cand_valid), 0);
      end
      halt = 1'b0;
      #0.1;
    end
    chk(ctr_ready == 1'b1, "R7", "ready before pop", int'(ctr_ready), 1);
    @(negedge clk);
    ctr_valid = 1'b0;
    arr_a = ~a ^ 32'h5555_AAAA;   // R2: later array changes must not matter
    arr_c = ~c;
    if (m == '0) begin
      chk(cand_valid == 1'b0, "R8", "empty AND gives no candidate", int'(cand_valid), 0);
      chk(ctr_ready == 1'b1, "R8", "ready one cycle after empty hit", int'(ctr_ready), 1);
      return;
    end
    first = 1'b1;
    for (int j = 0; j < WN; j++) begin
      if (!m[j]) continue;
      if (halt_mid && first) begin
        halt = 1'b1;
        for (int h = 0; h < 2; h++) begin
          @(negedge clk);
          chk(cand_valid == 1'b0, "R9", "cand_valid halted mid-drain", int'(cand_valid), 0);
          chk(ctr_ready == 1'b0, "R9", "ctr_ready halted mid-drain", int'(ctr_ready), 0);
        end
        halt = 1'b0;
        #0.1;
      end
      first = 1'b0;
      for (int s = 0; s < (p + j + k) % 3; s++) begin
        check_cand(p, j, "R6 stalled");
        @(negedge clk);
      end
      check_cand(p, j, "R2 match");
      cand_ready = 1'b1;
      @(negedge clk);
      cand_ready = 1'b0;
    end
    chk(cand_valid == 1'b0,
        (p < HALF || p >= NB - HALF) ? "R3" : "R4",
        "no extra candidate", int'(cand_valid), 0);
    chk(ctr_ready == 1'b1, "R7", "ready after last transfer", int'(ctr_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cand_valid == 1'b0, "R1", "cand_valid in reset", int'(cand_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cand_valid == 1'b0, "R1", "cand_valid after reset", int'(cand_valid), 0);
    chk(ctr_ready == 1'b1, "R1", "ctr_ready after reset", int'(ctr_ready), 1);
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < NB; p++)
        run_hit(k, p, (p % 7) == 3, (k == 0 || k == 2) && (p % 5) == 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule